// File: doc/BRIEF.md
# Immediate-Arithmetic 64-bit Core

This block is a minimal 64-bit processor core that executes only the register-immediate arithmetic group of a 64-bit RISC-style instruction set. It holds 32 general registers and a program counter. It reads 32-bit instruction words through a simple combinational instruction port, where the memory assembles each word little-endian. For each word it extracts the fields, sign-extends the 12-bit immediate, computes the result, writes the destination register and advances the program counter. A retire port reports every completed instruction: its address, its destination index and its result. This lets a surrounding system or a bench follow the architectural state.

Control is a three-state machine. In `ST_FETCH` the core presents the program counter on `imem_addr` and raises `imem_req`. At the clock edge that ends the state it captures `imem_rdata` into its instruction register and always moves to `ST_EXEC`. In `ST_EXEC` the captured word is decoded and executed. A recognised word takes the retire transition back to `ST_FETCH`. Any unrecognised word takes the trap transition into `ST_HALT`. `ST_HALT` only loops on itself, and only reset leaves it. On entry to the halt state the core latches the opcode, funct3 and funct7 fields of the rejected word on its error outputs and raises a sticky `halted` flag.

Top module: `imm_alu_core`

## Requirements
- R1: While reset is asserted and until the first fetch edge, `imem_addr` is 0x8000_0000 and `halted` and `ret_valid` are low. Register x2 starts at base plus memory size (0x8010_0000 by default). Every other register starts at zero.
- R2: Each instruction takes two cycles. `imem_req` is high only in the fetch cycle, and a one-cycle `ret_valid` pulse follows each executed instruction, so two retire pulses are always exactly two cycles apart.
- R3: `ret_pc` is the address the instruction was fetched from. The next fetch address is that value plus 4.
- R4: Register x0 always reads as zero. A write that targets x0 is discarded, although `ret_data` still shows the computed value.
- R5: The fields are opcode bits [6:0] (must be 0x13), rd [11:7], funct3 [14:12] and rs1 [19:15]. The immediate is bits [31:20], sign-extended to 64 bits. funct3 0 adds the immediate, 4 XORs it, 6 ORs it and 7 ANDs it.
- R6: funct3 2 writes 1 when rs1 is less than the immediate as signed numbers, and 0 otherwise. funct3 3 makes the same comparison unsigned, still against the sign-extended immediate.
- R7: funct3 1 shifts left. funct3 5 shifts right, arithmetic when bit 30 is 1 and logical when it is 0. The shift amount is the 6 bits [25:20].
- R8: A word is rejected when its opcode is not 0x13, when it has funct3 1 and bits [31:26] are not 000000, or when it has funct3 5 and bits [31:26] are neither 000000 nor 010000. A rejected word writes nothing and produces no retire pulse. `halted` rises one cycle after its execute cycle, and `err_opcode`, `err_funct3` and `err_funct7` show its bits [6:0], [14:12] and [31:25].
- R9: Once `halted` is high it stays high until reset. No further fetch (`imem_req` low) and no retire pulse occurs, and `imem_addr` holds the address of the rejected word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_req | output | 1 | High in the fetch cycle |
| imem_addr | output | 64 | Current program counter, used as fetch address |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, valid in the fetch cycle |
| ret_valid | output | 1 | One-cycle pulse after an instruction completes |
| ret_pc | output | 64 | Address of the completed instruction |
| ret_rd | output | 5 | Destination register index of the completed instruction |
| ret_data | output | 64 | Result computed by the completed instruction |
| halted | output | 1 | Sticky flag: a word was rejected |
| err_opcode | output | 7 | Bits [6:0] of the rejected word |
| err_funct3 | output | 3 | Bits [14:12] of the rejected word |
| err_funct7 | output | 7 | Bits [31:25] of the rejected word |

## Verification
After reset is released, the first fetch edge is one cycle away. The retire pulse for instruction k is visible on the falling edge that follows its execute edge, so the retire for instruction 0 appears at the second falling edge after release, and each later retire appears two falling edges after the one before. The bench samples only on falling edges. It checks each retire against a bench-side arithmetic model of the register file on the cycle the pulse is present, and it counts the falling edges since the last retire to confirm the two-cycle spacing. For a rejected word, `halted` is due on the second falling edge after the last retire, and the error fields are checked on that same edge. The quiet halt state is then held and checked over several more falling edges.

// File: rtl/immcore_pkg.sv
package immcore_pkg;

    localparam logic [6:0] OPC_OP_IMM = 7'h13;

    localparam logic [2:0] F3_ADD  = 3'd0;
    localparam logic [2:0] F3_SLL  = 3'd1;
    localparam logic [2:0] F3_SLT  = 3'd2;
    localparam logic [2:0] F3_SLTU = 3'd3;
    localparam logic [2:0] F3_XOR  = 3'd4;
    localparam logic [2:0] F3_SR   = 3'd5;
    localparam logic [2:0] F3_OR   = 3'd6;
    localparam logic [2:0] F3_AND  = 3'd7;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_HALT  = 2'd2
    } core_state_e;

    typedef enum logic [3:0] {
        ALU_ADD,
        ALU_SLL,
        ALU_SLT,
        ALU_SLTU,
        ALU_XOR,
        ALU_SRL,
        ALU_SRA,
        ALU_OR,
        ALU_AND
    } alu_op_e;

    typedef struct packed {
        logic       legal;
        alu_op_e    op;
        logic [4:0] rd;
        logic [4:0] rs1;
        logic [6:0] opcode;
        logic [2:0] funct3;
        logic [6:0] funct7;
    } decoded_t;

endpackage

// File: rtl/immcore_decode.sv
module immcore_decode
    import immcore_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int SH_W = $clog2(XLEN)
) (
    input  logic [31:0]      instr,
    output decoded_t         dec,
    output logic [XLEN-1:0]  imm,
    output logic [SH_W-1:0]  shamt
);

    // Bits above the shift amount; bit 30 inside them selects arithmetic.
    localparam int UPW = 12 - SH_W;
    localparam logic [UPW-1:0] SRA_MARK = UPW'(1) << (10 - SH_W);

    logic [UPW-1:0] upper;
    assign upper = instr[31:20+SH_W];

    always_comb begin
        dec.opcode = instr[6:0];
        dec.rd     = instr[11:7];
        dec.funct3 = instr[14:12];
        dec.rs1    = instr[19:15];
        dec.funct7 = instr[31:25];
        dec.op     = ALU_ADD;
        dec.legal  = (instr[6:0] == OPC_OP_IMM);
        unique case (instr[14:12])
            F3_ADD:  dec.op = ALU_ADD;
            F3_SLL: begin
                dec.op = ALU_SLL;
                if (upper != '0) dec.legal = 1'b0;
            end
            F3_SLT:  dec.op = ALU_SLT;
            F3_SLTU: dec.op = ALU_SLTU;
            F3_XOR:  dec.op = ALU_XOR;
            F3_SR: begin
                dec.op = instr[30] ? ALU_SRA : ALU_SRL;
                if (upper != '0 && upper != SRA_MARK) dec.legal = 1'b0;
            end
            F3_OR:   dec.op = ALU_OR;
            F3_AND:  dec.op = ALU_AND;
            default: dec.legal = 1'b0;
        endcase
    end

    assign imm   = {{(XLEN-12){instr[31]}}, instr[31:20]};
    assign shamt = instr[20 +: SH_W];

endmodule

// File: rtl/immcore_alu.sv
module immcore_alu
    import immcore_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int SH_W = $clog2(XLEN)
) (
    input  alu_op_e          op,
    input  logic [XLEN-1:0]  src,
    input  logic [XLEN-1:0]  imm,
    input  logic [SH_W-1:0]  shamt,
    output logic [XLEN-1:0]  result
);

    always_comb begin
        result = '0;
        unique case (op)
            ALU_ADD:  result = src + imm;
            ALU_SLL:  result = src << shamt;
            ALU_SLT:  result = {{(XLEN-1){1'b0}}, ($signed(src) < $signed(imm))};
            ALU_SLTU: result = {{(XLEN-1){1'b0}}, (src < imm)};
            ALU_XOR:  result = src ^ imm;
            ALU_SRL:  result = src >> shamt;
            ALU_SRA:  result = $unsigned($signed(src) >>> shamt);
            ALU_OR:   result = src | imm;
            ALU_AND:  result = src & imm;
            default:  result = '0;
        endcase
    end

endmodule

// File: rtl/immcore_regfile.sv
module immcore_regfile #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    parameter int SP_IDX = 2,
    parameter logic [XLEN-1:0] SP_INIT = '0,
    localparam int RA_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RA_W-1:0]  rd_addr,
    output logic [XLEN-1:0]  rd_data,
    input  logic             wr_en,
    input  logic [RA_W-1:0]  wr_addr,
    input  logic [XLEN-1:0]  wr_data
);

    logic [NREG-1:0][XLEN-1:0] file_q;

    // Entry zero has no storage: it is a constant.
    assign file_q[0] = '0;

    for (genvar g = 1; g < NREG; g++) begin : g_reg
        localparam logic [XLEN-1:0] INIT = (g == SP_IDX) ? SP_INIT : '0;
        logic [XLEN-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= INIT;
            end else if (wr_en && wr_addr == RA_W'(g)) begin
                q <= wr_data;
            end
        end
        assign file_q[g] = q;
    end

    assign rd_data = file_q[rd_addr];

    assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && wr_addr == rd_addr)
        |=> (!$stable(rd_addr) || rd_data == $past(wr_data)));

    assert_x0_discard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (rd_addr != '0 || rd_data == '0));

endmodule

// File: rtl/imm_alu_core.sv
module imm_alu_core
    import immcore_pkg::*;
#(
    parameter int          XLEN     = 64,
    parameter int          NREG     = 32,
    parameter int          SP_IDX   = 2,
    parameter logic [63:0] MEM_BASE = 64'h0000_0000_8000_0000,
    parameter logic [63:0] MEM_SIZE = 64'h0000_0000_0010_0000,
    localparam int RA_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             imem_req,
    output logic [XLEN-1:0]  imem_addr,
    input  logic [31:0]      imem_rdata,
    output logic             ret_valid,
    output logic [XLEN-1:0]  ret_pc,
    output logic [RA_W-1:0]  ret_rd,
    output logic [XLEN-1:0]  ret_data,
    output logic             halted,
    output logic [6:0]       err_opcode,
    output logic [2:0]       err_funct3,
    output logic [6:0]       err_funct7
);

    localparam int SH_W = $clog2(XLEN);
    localparam logic [63:0] SP_TOP = MEM_BASE + MEM_SIZE;
    localparam logic [XLEN-1:0] PC_INIT = XLEN'(MEM_BASE);
    localparam logic [XLEN-1:0] SP_INIT = XLEN'(SP_TOP);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

    core_state_e state, state_nx;
    logic [XLEN-1:0] pc;
    logic [31:0]     ir;

    decoded_t        dec;
    logic [XLEN-1:0] imm_x;
    logic [SH_W-1:0] shamt;
    logic [XLEN-1:0] src_val;
    logic [XLEN-1:0] alu_res;
    logic            commit;

    immcore_decode #(.XLEN(XLEN)) u_decode (
        .instr (ir),
        .dec   (dec),
        .imm   (imm_x),
        .shamt (shamt)
    );

    immcore_regfile #(
        .XLEN   (XLEN),
        .NREG   (NREG),
        .SP_IDX (SP_IDX),
        .SP_INIT(SP_INIT)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (RA_W'(dec.rs1)),
        .rd_data (src_val),
        .wr_en   (commit),
        .wr_addr (RA_W'(dec.rd)),
        .wr_data (alu_res)
    );

    immcore_alu #(.XLEN(XLEN)) u_alu (
        .op     (dec.op),
        .src    (src_val),
        .imm    (imm_x),
        .shamt  (shamt),
        .result (alu_res)
    );

    assign commit    = (state == ST_EXEC) && dec.legal;
    assign imem_req  = (state == ST_FETCH);
    assign imem_addr = pc;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH: state_nx = ST_EXEC;
            ST_EXEC:  state_nx = dec.legal ? ST_FETCH : ST_HALT;
            ST_HALT:  state_nx = ST_HALT;
            default:  state_nx = ST_HALT;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc         <= PC_INIT;
            ir         <= '0;
            ret_valid  <= 1'b0;
            ret_pc     <= '0;
            ret_rd     <= '0;
            ret_data   <= '0;
            halted     <= 1'b0;
            err_opcode <= '0;
            err_funct3 <= '0;
            err_funct7 <= '0;
        end else begin
            ret_valid <= 1'b0;
            unique case (state)
                ST_FETCH: ir <= imem_rdata;
                ST_EXEC: begin
                    if (dec.legal) begin
                        ret_valid <= 1'b1;
                        ret_pc    <= pc;
                        ret_rd    <= RA_W'(dec.rd);
                        ret_data  <= alu_res;
                        pc        <= pc + PC_STEP;
                    end else begin
                        halted     <= 1'b1;
                        err_opcode <= dec.opcode;
                        err_funct3 <= dec.funct3;
                        err_funct7 <= dec.funct7;
                    end
                end
                ST_HALT: halted <= 1'b1;
                default: halted <= 1'b1;
            endcase
        end
    end

    assert_retire_next_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> (imem_addr == ret_pc + PC_STEP));

    assert_retire_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> !ret_valid);

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(imem_addr)));

    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!ret_valid && !imem_req));

    assert_halt_from_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> ($past(state) == ST_EXEC));

endmodule

// File: tb/imm_alu_core_bench.sv
module imm_alu_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] BASE = 64'h0000_0000_8000_0000;
    localparam logic [63:0] SP0  = 64'h0000_0000_8010_0000;
    localparam int MEM_BYTES = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_req;
    logic [63:0] imem_addr;
    logic [31:0] imem_rdata;
    logic        ret_valid;
    logic [63:0] ret_pc;
    logic [4:0]  ret_rd;
    logic [63:0] ret_data;
    logic        halted;
    logic [6:0]  err_opcode;
    logic [2:0]  err_funct3;
    logic [6:0]  err_funct7;

    always #(CLK_PERIOD/2) clk = ~clk;

    imm_alu_core u_imm_alu_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_req   (imem_req),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .ret_valid  (ret_valid),
        .ret_pc     (ret_pc),
        .ret_rd     (ret_rd),
        .ret_data   (ret_data),
        .halted     (halted),
        .err_opcode (err_opcode),
        .err_funct3 (err_funct3),
        .err_funct7 (err_funct7)
    );

    // Byte memory, words assembled little-endian
    logic [7:0] mem_b [0:MEM_BYTES-1];

    function automatic logic [31:0] fetch_word(logic [63:0] a);
        logic [63:0] off;
        off = a - BASE;
        if (off >= 64'(MEM_BYTES)) return 32'h0;
        return {mem_b[off[11:0] + 12'd3], mem_b[off[11:0] + 12'd2],
                mem_b[off[11:0] + 12'd1], mem_b[off[11:0]]};
    endfunction

    always_comb imem_rdata = fetch_word(imem_addr);

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Program store
    int          n_prog = 0;
    logic [31:0] prog_w   [0:1023];
    string       prog_tag [0:1023];

    function automatic logic [31:0] enc(logic [2:0] f3, int rd, int rs1, logic [11:0] imm12);
        return {imm12, 5'(rs1), f3, 5'(rd), 7'h13};
    endfunction

    task automatic emit(input logic [31:0] w, input string t);
        prog_w[n_prog]   = w;
        prog_tag[n_prog] = t;
        n_prog++;
    endtask

    // Bench-side model of the register file
    logic [63:0] mregs [0:31];

    function automatic logic [63:0] model_exec(logic [31:0] w, logic [63:0] a);
        logic [63:0] imm;
        int sh;
        imm = {{52{w[31]}}, w[31:20]};
        sh  = int'(w[25:20]);
        case (w[14:12])
            3'd0: return a + imm;
            3'd1: return a << sh;
            3'd2: return (a[63] != imm[63]) ? {63'd0, a[63]} : {63'd0, (a < imm)};
            3'd3: return {63'd0, (a < imm)};
            3'd4: return a ^ imm;
            3'd5: begin
                if (w[30] && a[63]) return (a >> sh) | ~(64'hFFFF_FFFF_FFFF_FFFF >> sh);
                return a >> sh;
            end
            3'd6: return a | imm;
            default: return a & imm;
        endcase
    endfunction

    task automatic run_prog(input int n_legal, input logic [31:0] bad, input string label);
        int k;
        int since_ret;
        bit seen_halt;
        logic [63:0] expv;
        logic [31:0] w;
        for (int i = 0; i < MEM_BYTES; i++) mem_b[i] = 8'h00;
        for (int i = 0; i < n_legal; i++) begin
            for (int b = 0; b < 4; b++) mem_b[i*4+b] = prog_w[i][b*8 +: 8];
        end
        for (int b = 0; b < 4; b++) mem_b[n_legal*4+b] = bad[b*8 +: 8];
        for (int r = 0; r < 32; r++) mregs[r] = 64'd0;
        mregs[2] = SP0;

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(imem_addr == BASE, "R1", {label, " reset pc"}, imem_addr, BASE);
        chk(!halted && !ret_valid, "R1", {label, " reset flags"}, {62'd0, halted, ret_valid}, 64'd0);
        chk(imem_req, "R2", {label, " fetch request at reset"}, {63'd0, imem_req}, 64'd1);
        rst_n = 1'b1;

        k = 0;
        since_ret = 0;
        seen_halt = 1'b0;
        for (int cyc = 0; cyc < 4 * n_legal + 40; cyc++) begin
            @(negedge clk);
            since_ret++;
            if (ret_valid) begin
                w = prog_w[k];
                expv = model_exec(w, mregs[w[19:15]]);
                chk(since_ret == 2, "R2", {label, " retire spacing"}, 64'(since_ret), 64'd2);
                chk(ret_data == expv, prog_tag[k], {label, " result"}, ret_data, expv);
                chk(ret_rd == w[11:7], "R5", {label, " rd field"}, 64'(ret_rd), 64'(w[11:7]));
                chk(ret_pc == BASE + 64'(4 * k), "R3", {label, " retire pc"}, ret_pc, BASE + 64'(4 * k));
                chk(imem_req && imem_addr == ret_pc + 64'd4, "R3", {label, " next fetch addr"},
                    imem_addr, ret_pc + 64'd4);
                if (w[11:7] != 5'd0) mregs[w[11:7]] = expv;
                since_ret = 0;
                k++;
            end else if (!halted) begin
                chk(!imem_req, "R2", {label, " no request in execute"}, {63'd0, imem_req}, 64'd0);
            end
            if (halted) begin
                seen_halt = 1'b1;
                break;
            end
        end

        chk(seen_halt, "R8", {label, " halt reached"}, {63'd0, seen_halt}, 64'd1);
        chk(k == n_legal, "R8", {label, " retire count"}, 64'(k), 64'(n_legal));
        chk(since_ret == 2, "R8", {label, " halt timing"}, 64'(since_ret), 64'd2);
        chk(err_opcode == bad[6:0], "R8", {label, " err opcode"}, 64'(err_opcode), 64'(bad[6:0]));
        chk(err_funct3 == bad[14:12], "R8", {label, " err funct3"}, 64'(err_funct3), 64'(bad[14:12]));
        chk(err_funct7 == bad[31:25], "R8", {label, " err funct7"}, 64'(err_funct7), 64'(bad[31:25]));
        for (int q = 0; q < 5; q++) begin
            @(negedge clk);
            chk(halted && !imem_req && !ret_valid, "R9", {label, " halt quiet"},
                {61'd0, halted, imem_req, ret_valid}, 64'd4);
            chk(imem_addr == BASE + 64'(4 * n_legal), "R9", {label, " halt pc"},
                imem_addr, BASE + 64'(4 * n_legal));
        end
    endtask

    function automatic string tag_of(logic [2:0] f3);
        case (f3)
            3'd1, 3'd5: return "R7";
            3'd2, 3'd3: return "R6";
            default:    return "R5";
        endcase
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL R2 watchdog: actual=%h expected=%h", 64'd0, 64'd1);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin : main
        int srcs [6];
        logic [11:0] imms [8];
        logic [11:0] imm12;
        int cnt;
        srcs = '{0, 1, 2, 3, 4, 6};
        imms = '{12'h000, 12'h001, 12'hfff, 12'h7ff, 12'h800, 12'h555, 12'h03f, 12'h020};

        // Setup section
        emit(enc(3'd0, 1, 0, 12'hfff), "R5");   // x1 = -1
        emit(enc(3'd0, 3, 0, 12'h001), "R5");   // x3 = 1
        emit(enc(3'd1, 3, 3, 12'h03f), "R7");   // x3 = 1 << 63
        emit(enc(3'd0, 4, 0, 12'h7ff), "R5");   // x4 = 2047
        emit(enc(3'd0, 5, 2, 12'h000), "R1");   // x5 = reset stack pointer
        emit(enc(3'd0, 7, 31, 12'h000), "R1");  // x31 cleared at reset
        emit(enc(3'd0, 0, 1, 12'h006), "R4");   // write to x0, result 5 discarded
        emit(enc(3'd0, 8, 0, 12'h000), "R4");   // x0 still reads zero
        emit(enc(3'd0, 6, 0, 12'h5a5), "R5");
        emit(enc(3'd1, 6, 6, 12'h028), "R7");
        emit(enc(3'd6, 6, 6, 12'h123), "R5");

        // Sweep of every operation over operand and immediate corners
        cnt = 0;
        for (int f = 0; f < 8; f++) begin
            for (int s = 0; s < 6; s++) begin
                for (int m = 0; m < 8; m++) begin
                    imm12 = imms[m];
                    if (f == 1) imm12 = {6'd0, imms[m][5:0]};
                    if (f == 5) imm12 = {1'b0, m[0], 4'd0, imms[m][5:0]};
                    emit(enc(3'(f), 9 + (cnt % 23), srcs[s], imm12), tag_of(3'(f)));
                    cnt++;
                end
            end
        end
        // Every 6-bit shift amount
        for (int sh = 0; sh < 64; sh++) begin
            emit(enc(3'd1, 9 + (sh % 23), 6, {6'd0, 6'(sh)}), "R7");
            emit(enc(3'd5, 9 + ((sh + 7) % 23), 3, {6'd0, 6'(sh)}), "R7");
            emit(enc(3'd5, 9 + ((sh + 13) % 23), 3, {6'b010000, 6'(sh)}), "R7");
        end

        // Stopping words: other opcode, bad left-shift upper bits, bad right-shift upper bits, load opcode
        run_prog(n_prog, 32'h0020_8033, "full");
        run_prog(3, {6'b010000, 6'd1, 5'd1, 3'd1, 5'd9, 7'h13}, "sll_bad");
        run_prog(2, {6'b000001, 6'd3, 5'd1, 3'd5, 5'd9, 7'h13}, "sr_bad");
        run_prog(1, {7'h7f, 5'd0, 5'd1, 3'd3, 5'd2, 7'h03}, "load_op");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule